// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

This block joins two 8-bit buses, A and B, through a pair of storage registers per channel. Each direction can pass live data from the opposite bus or replay what its register last captured. The buses are carried as split vectors: an external input, an output, and one drive-enable bit per bus. The value seen on a bus, called the resolved bus value, is the block's output while it drives that bus and the external input otherwise. Two channels sit side by side, and each has its own capture strobes, selects and enables.

The capture strobes are clock enables sampled on the system clock. A register captures whenever its strobe is high, whatever the selects and enables are doing. The A-side enable is active low and the B-side enable is active high. With both enables on and both selects in live mode, a channel holds each bus at its last resolved value. A holding register breaks the loop that would otherwise form. A conflict flag reports when the block drives a bus that the environment also marks as driven.

Top module: `dual_bus_xcvr`

## Requirements
- R1: The two channels are independent. Controls and data of one channel never change the registers or outputs of the other.
- R2: On a clock edge with `cap_ab_i` high, the channel's A-to-B register loads the resolved A value. Selects and enables have no effect on this. With the strobe low, the register keeps its value.
- R3: On a clock edge with `cap_ba_i` high, the B-to-A register loads the resolved B value. Selects and enables have no effect on this. With the strobe low, the register keeps its value.
- R4: `b_oe_o` equals `en_ab_i`, which is active high. `a_oe_o` equals the inverse of `en_ba_n_i`, which is active low.
- R5: When B is driven and `sel_ab_i`=0, `b_out_o` is the resolved A value. When `sel_ab_i`=1, `b_out_o` is the A-to-B register. `sel_ba_i` picks between live B and the B-to-A register for `a_out_o` in the same way.
- R6: With `en_ab_i`=0 and `en_ba_n_i`=1, neither bus is driven. Captures still take place.
- R7: With both buses driven and both selects 0, `a_out_o` and `b_out_o` carry each bus's resolved value from the previous cycle. They stay unchanged for as long as this mode lasts, and the external inputs have no effect.
- R8: With both buses driven and both selects 1, B carries the A-to-B register and A carries the B-to-A register.
- R9: Both strobes may be raised in the same cycle. If B is driven live from A, both registers load the external A value. If B is driven from the stored register, the B-to-A register loads the old A-to-B contents.
- R10: `conflict_o[c]` is high in the same cycle whenever channel c drives A while `a_ext_i[c]` is high, or drives B while `b_ext_i[c]` is high.
- R11: A low `rst_n` clears all registers and held bus values at once, without waiting for a clock edge. Release takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_ab_i | input | 2 | Per-channel strobe: load resolved A into the A-to-B register |
| cap_ba_i | input | 2 | Per-channel strobe: load resolved B into the B-to-A register |
| en_ab_i | input | 2 | Per-channel drive enable for bus B, active high |
| en_ba_n_i | input | 2 | Per-channel drive enable for bus A, active low |
| sel_ab_i | input | 2 | Per-channel source for bus B: 0 live A, 1 stored |
| sel_ba_i | input | 2 | Per-channel source for bus A: 0 live B, 1 stored |
| a_in_i | input | 16 | External A data, channel c at bits [8c+7:8c] |
| a_ext_i | input | 2 | Per-channel marker that an outside source drives A |
| b_in_i | input | 16 | External B data, channel c at bits [8c+7:8c] |
| b_ext_i | input | 2 | Per-channel marker that an outside source drives B |
| a_out_o | output | 16 | Data the block drives onto A |
| a_oe_o | output | 2 | High when the block drives A |
| b_out_o | output | 16 | Data the block drives onto B |
| b_oe_o | output | 2 | High when the block drives B |
| conflict_o | output | 2 | Per-channel drive conflict flag |

## Verification
The capture assertions take the resolved bus value in the cycle before the edge as ground truth. They therefore assume that the external inputs and markers stay steady across each edge, and the stimulus meets this by changing inputs only at the falling edge. The hold-mode assertion needs two consecutive hold cycles out of reset. Random control mixes reach that mode about one cycle in sixteen, and a directed run keeps it for several cycles while the external data changes. Simultaneous captures under both select settings are driven on purpose, because random traffic hits the stored-select case only rarely.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int XCVR_W_DEF   = 8;
  localparam int XCVR_NCH_DEF = 2;
  localparam int XCVR_SYNC    = 2;

  typedef struct packed {
    logic cap_ab;
    logic cap_ba;
    logic en_ab;
    logic en_ba_n;
    logic sel_ab;
    logic sel_ba;
  } xcvr_ctrl_t;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb q_d = ld ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/xcvr_channel.sv
module xcvr_channel
  import bus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  xcvr_ctrl_t   ctl,
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic         conflict
);
  logic [W-1:0] ab_q, ba_q, hold_a_q, hold_b_q;
  logic [W-1:0] res_a, res_b;
  logic         drv_a, drv_b, hold_mode;

  always_comb begin
    drv_a     = ~ctl.en_ba_n;
    drv_b     = ctl.en_ab;
    hold_mode = drv_a & drv_b & ~ctl.sel_ab & ~ctl.sel_ba;

    if (ctl.sel_ab)  b_out = ab_q;
    else if (hold_mode) b_out = hold_b_q;
    else if (drv_a)  b_out = ba_q;
    else             b_out = a_in;

    if (ctl.sel_ba)  a_out = ba_q;
    else if (hold_mode) a_out = hold_a_q;
    else if (drv_b)  a_out = ab_q;
    else             a_out = b_in;

    res_a    = drv_a ? a_out : a_in;
    res_b    = drv_b ? b_out : b_in;
    a_oe     = drv_a;
    b_oe     = drv_b;
    conflict = (drv_a & a_ext) | (drv_b & b_ext);
  end

  xcvr_store_reg #(.W(W)) u_ab   (.clk(clk), .rst_n(rst_n), .ld(ctl.cap_ab), .d(res_a), .q(ab_q));
  xcvr_store_reg #(.W(W)) u_ba   (.clk(clk), .rst_n(rst_n), .ld(ctl.cap_ba), .d(res_b), .q(ba_q));
  xcvr_store_reg #(.W(W)) u_hold_a (.clk(clk), .rst_n(rst_n), .ld(1'b1), .d(res_a), .q(hold_a_q));
  xcvr_store_reg #(.W(W)) u_hold_b (.clk(clk), .rst_n(rst_n), .ld(1'b1), .d(res_b), .q(hold_b_q));

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cap_ab |=> ab_q == $past(res_a)); // R2
  AST_AB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.cap_ab |=> $stable(ab_q)); // R2
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cap_ba |=> ba_q == $past(res_b)); // R3
  AST_BA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.cap_ba |=> $stable(ba_q)); // R3
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mode && $past(hold_mode) && $past(rst_n)) |-> (a_out == $past(a_out) && b_out == $past(b_out))); // R7
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import bus_xcvr_pkg::*;
#(
  parameter int W   = XCVR_W_DEF,
  parameter int NCH = XCVR_NCH_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   cap_ab_i,
  input  logic [NCH-1:0]   cap_ba_i,
  input  logic [NCH-1:0]   en_ab_i,
  input  logic [NCH-1:0]   en_ba_n_i,
  input  logic [NCH-1:0]   sel_ab_i,
  input  logic [NCH-1:0]   sel_ba_i,
  input  logic [NCH*W-1:0] a_in_i,
  input  logic [NCH-1:0]   a_ext_i,
  input  logic [NCH*W-1:0] b_in_i,
  input  logic [NCH-1:0]   b_ext_i,
  output logic [NCH*W-1:0] a_out_o,
  output logic [NCH-1:0]   a_oe_o,
  output logic [NCH*W-1:0] b_out_o,
  output logic [NCH-1:0]   b_oe_o,
  output logic [NCH-1:0]   conflict_o
);
  logic rst_sync_n;

  xcvr_rst_sync #(.STAGES(XCVR_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    xcvr_ctrl_t ctl;
    always_comb begin
      ctl.cap_ab  = cap_ab_i[c];
      ctl.cap_ba  = cap_ba_i[c];
      ctl.en_ab   = en_ab_i[c];
      ctl.en_ba_n = en_ba_n_i[c];
      ctl.sel_ab  = sel_ab_i[c];
      ctl.sel_ba  = sel_ba_i[c];
    end

    xcvr_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .ctl(ctl),
      .a_in(a_in_i[c*W +: W]), .a_ext(a_ext_i[c]),
      .b_in(b_in_i[c*W +: W]), .b_ext(b_ext_i[c]),
      .a_out(a_out_o[c*W +: W]), .a_oe(a_oe_o[c]),
      .b_out(b_out_o[c*W +: W]), .b_oe(b_oe_o[c]),
      .conflict(conflict_o[c]));
  end
endmodule

// File: tb/dual_bus_xcvr_tb.sv
module dual_bus_xcvr_tb_top;
  localparam int W = 8;
  localparam int NCH = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [NCH-1:0]   cap_ab, cap_ba, en_ab, en_ba_n, sel_ab, sel_ba, a_ext, b_ext;
  logic [NCH*W-1:0] a_in, b_in;
  logic [NCH*W-1:0] a_out, b_out;
  logic [NCH-1:0]   a_oe, b_oe, conflict;

  dual_bus_xcvr #(.W(W), .NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .en_ab_i(en_ab), .en_ba_n_i(en_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_in_i(a_in), .a_ext_i(a_ext), .b_in_i(b_in), .b_ext_i(b_ext),
    .a_out_o(a_out), .a_oe_o(a_oe), .b_out_o(b_out), .b_oe_o(b_oe),
    .conflict_o(conflict));

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] m_ab [NCH], m_ba [NCH], m_ha [NCH], m_hb [NCH];
  logic [W-1:0] x_ab [NCH], x_ba [NCH], x_ha [NCH], x_hb [NCH];

  task automatic chk(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      m_ab[c] = '0; m_ba[c] = '0; m_ha[c] = '0; m_hb[c] = '0;
    end
  endtask

  task automatic set_ch(int c, bit cab, bit cba, bit eab, bit eban, bit sab, bit sba,
                        logic [W-1:0] ai, bit ax, logic [W-1:0] bi, bit bx);
    cap_ab[c] = cab; cap_ba[c] = cba; en_ab[c] = eab; en_ba_n[c] = eban;
    sel_ab[c] = sab; sel_ba[c] = sba; a_ext[c] = ax; b_ext[c] = bx;
    a_in[c*W +: W] = ai; b_in[c*W +: W] = bi;
  endtask

  // Inputs are set after a falling edge; outputs checked 1 ns later, model advanced at the rising edge.
  task automatic eval_cycle();
    #1;
    for (int c = 0; c < NCH; c++) begin
      bit da, db, hm;
      logic [W-1:0] ea, eb, ra, rb, ai, bi;
      string tg;
      ai = a_in[c*W +: W]; bi = b_in[c*W +: W];
      da = !en_ba_n[c]; db = en_ab[c];
      hm = da && db && !sel_ab[c] && !sel_ba[c];
      eb = sel_ab[c] ? m_ab[c] : hm ? m_hb[c] : da ? m_ba[c] : ai;
      ea = sel_ba[c] ? m_ba[c] : hm ? m_ha[c] : db ? m_ab[c] : bi;
      ra = da ? ea : ai;
      rb = db ? eb : bi;
      chk(b_oe[c] == db, "R4", "b_oe", W'(b_oe[c]), W'(db));
      chk(a_oe[c] == da, "R4", "a_oe", W'(a_oe[c]), W'(da));
      if (!da && !db) chk((a_oe[c] | b_oe[c]) == 1'b0, "R6", "isolation oe", W'(a_oe[c] | b_oe[c]), '0);
      tg = hm ? "R7" : (da && db && sel_ab[c] && sel_ba[c]) ? "R8" : "R5";
      if (db) chk(b_out[c*W +: W] === eb, tg, "b_out", b_out[c*W +: W], eb);
      if (da) chk(a_out[c*W +: W] === ea, tg, "a_out", a_out[c*W +: W], ea);
      chk(conflict[c] == ((da && a_ext[c]) || (db && b_ext[c])), "R10", "conflict",
          W'(conflict[c]), W'((da && a_ext[c]) || (db && b_ext[c])));
      x_ab[c] = cap_ab[c] ? ra : m_ab[c];
      x_ba[c] = cap_ba[c] ? rb : m_ba[c];
      x_ha[c] = ra; x_hb[c] = rb;
    end
    @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      m_ab[c] = x_ab[c]; m_ba[c] = x_ba[c]; m_ha[c] = x_ha[c]; m_hb[c] = x_hb[c];
    end
    @(negedge clk);
  endtask

  task automatic quiet_all();
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 0, 1, 0, 0, '0, 0, '0, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    quiet_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1977));
    do_reset();

    // R11: registers read back zero after reset
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 1, 0, 1, 1, 8'hA5, 0, 8'h5A, 0);
    #1;
    chk(b_out[W-1:0] == '0, "R11", "b_out after reset", b_out[W-1:0], '0);
    chk(a_out[2*W-1:W] == '0, "R11", "a_out after reset", a_out[2*W-1:W], '0);
    eval_cycle();

    // R2 / R3: capture in isolation, then read back through stored selects
    quiet_all();
    set_ch(0, 1, 1, 0, 1, 1, 1, 8'h5A, 1, 8'hC3, 1);
    eval_cycle();
    set_ch(0, 0, 0, 1, 0, 1, 1, 8'h00, 0, 8'h00, 0);
    #1;
    chk(b_out[W-1:0] == 8'h5A, "R2", "stored A", b_out[W-1:0], 8'h5A);
    chk(a_out[W-1:0] == 8'hC3, "R3", "stored B", a_out[W-1:0], 8'hC3);
    eval_cycle();

    // R9: simultaneous captures, live select then stored select
    set_ch(0, 1, 1, 1, 1, 0, 0, 8'h3C, 0, 8'h00, 0);
    eval_cycle();
    set_ch(0, 1, 1, 1, 1, 1, 0, 8'h99, 0, 8'h00, 0);
    eval_cycle();
    set_ch(0, 0, 0, 1, 0, 1, 1, 8'h00, 0, 8'h00, 0);
    #1;
    chk(b_out[W-1:0] == 8'h99, "R9", "ab after stored dual capture", b_out[W-1:0], 8'h99);
    chk(a_out[W-1:0] == 8'h3C, "R9", "ba after stored dual capture", a_out[W-1:0], 8'h3C);
    eval_cycle();

    // R1: channel 1 untouched by channel 0 traffic
    set_ch(1, 0, 0, 1, 0, 1, 1, 8'hFF, 0, 8'hFF, 0);
    #1;
    chk(b_out[2*W-1:W] == '0, "R1", "ch1 ab", b_out[2*W-1:W], '0);
    chk(a_out[2*W-1:W] == '0, "R1", "ch1 ba", a_out[2*W-1:W], '0);
    eval_cycle();

    // R7: bus hold with changing external data
    quiet_all();
    set_ch(0, 0, 0, 0, 1, 0, 0, 8'h11, 0, 8'h22, 0);
    eval_cycle();
    for (int i = 0; i < 4; i++) begin
      set_ch(0, 0, 0, 1, 0, 0, 0, 8'(8'hF0 + i), 0, 8'(8'hE0 + i), 0);
      #1;
      chk(a_out[W-1:0] == 8'h11, "R7", "held A", a_out[W-1:0], 8'h11);
      chk(b_out[W-1:0] == 8'h22, "R7", "held B", b_out[W-1:0], 8'h22);
      eval_cycle();
    end

    // R10: conflict only while driving a marked bus
    quiet_all();
    set_ch(1, 0, 0, 0, 0, 1, 1, '0, 1, '0, 1);
    #1;
    chk(conflict == 2'b10, "R10", "A conflict", W'(conflict), 8'h02);
    eval_cycle();
    set_ch(1, 0, 0, 0, 1, 1, 1, '0, 1, '0, 1);
    #1;
    chk(conflict == 2'b00, "R10", "isolated no conflict", W'(conflict), 8'h00);
    eval_cycle();

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [31:0] r;
        r = $urandom;
        set_ch(c, r[0], r[1], r[2], r[3], r[4], r[5], 8'($urandom), r[6] & r[7],
               8'($urandom), r[8] & r[9]);
      end
      eval_cycle();
    end

    // R11: asynchronous clear mid-run
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 1, 0, 1, 1, '0, 0, '0, 0);
    #1;
    rst_n = 1'b0;
    #1;
    chk(b_out == '0 ? 1'b1 : 1'b0, "R11", "async clear b", b_out[W-1:0], '0);
    chk(a_out == '0 ? 1'b1 : 1'b0, "R11", "async clear a", a_out[W-1:0], '0);
    @(negedge clk);
    quiet_all();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_clear();
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 1, 0, 1, 1, '0, 0, '0, 0);
    eval_cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule